// File: doc/BRIEF.md
# Engine Reset Handshake Controller

This block coordinates resets for a set of processing engines and for a group of reset domains. Each engine has a control word on a small register bus. Software asks an engine to stop, waits until the block reports that the engine has gone quiet, and then resets it. Software can also withdraw the request. An engine that signals a catastrophic fault skips the handshake. The fault is latched in the control word, and software acknowledges it with a write that makes the hardware clear the flag.

The engine control word uses masked writes. The upper half of a write selects which low bits may change, so software can change one bit without reading the word first. Through a separate domain word, software writes a mask of domains to reset. Each selected domain drives its reset output for a fixed number of cycles, and its bit reads as 1 until that pulse ends.

Each engine has its own state machine with the states ES_IDLE, ES_QUIESCE, ES_READY and ES_CATERR. It moves from ES_IDLE to ES_QUIESCE on a request write. It moves from ES_QUIESCE to ES_READY when the engine is idle. A cancel write returns ES_QUIESCE or ES_READY to ES_IDLE. A fault input moves any state to ES_CATERR, and the fault acknowledge write moves ES_CATERR back to ES_IDLE. Each domain has a timer with the states DS_IDLE and DS_PULSE. It moves from DS_IDLE to DS_PULSE on a start bit, and from DS_PULSE back to DS_IDLE when the count runs out.

Top module: `eng_reset_ctrl`

## Requirements
- R1: After reset, every engine word and the domain word read 0, and all quiesce and domain reset outputs are low.
- R2: An engine word write changes low bit n only when bit n+16 of the same write is 1; a write without the enable bit leaves the word unchanged.
- R3: A write setting bit 0 (request, enable bit 16) makes bit 0 read 1 and drives that engine's quiesce output high. Bit 1 (ready) reads 1 one cycle after the engine idle input is sampled high while the request is pending, and stays low while idle is low.
- R4: Bit 1 is read-only: a masked write to it has no effect.
- R5: A write clearing bit 0 (enable bit 16, value 0) clears request and ready in the next cycle and drops the quiesce output.
- R6: A one-cycle pulse on an engine fault input sets bit 2 (fault), clears request and ready, and makes that engine ignore request writes while bit 2 is set. Other engines are not affected.
- R7: A write of 1 to bit 2 with enable bit 18 set clears bit 2 to 0 (the acknowledge) and returns the engine to idle.
- R8: In the domain word (address 0), writing 1 to a valid domain bit drives that domain's reset output high for exactly RST_CYCLES cycles, starting the cycle after the write, and the bit reads 1 for the same cycles.
- R9: Domain bit 0 (full reset) drives the reset output of every valid domain while it is active.
- R10: Writing a domain bit again while it is active neither restarts nor lengthens its pulse.
- R11: Domain bit 6 and all bits above 7 are not implemented: writing them starts nothing, and they read 0. The valid domain bits are 0 to 5 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address: 0 is the domain word, e+1 is engine e |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| eng_idle_i | input | NUM_ENG | Engine has quiesced |
| eng_err_i | input | NUM_ENG | Engine catastrophic fault |
| eng_quiesce_o | output | NUM_ENG | Request to the engine to stop work |
| dom_rst_o | output | DOM_W | Per-domain reset outputs |

## Verification
The assertions assume that the fault inputs arrive as short pulses and that the idle inputs are ordinary synchronous levels. The bench keeps to this. It pulses each fault input for one cycle and changes inputs and bus fields only on falling edges. It writes one register per cycle, with the strobe held for a single cycle. It never requests a domain it is not watching, so each pulse length is counted from a known write.

// File: rtl/eng_rst_pkg.sv
package eng_rst_pkg;
    localparam int CTL_REQ    = 0;
    localparam int CTL_RDY    = 1;
    localparam int CTL_CAT    = 2;
    localparam int CTL_EN_OFS = 16;

    typedef enum logic [1:0] {
        ES_IDLE,
        ES_QUIESCE,
        ES_READY,
        ES_CATERR
    } eng_state_e;

    typedef enum logic {
        DS_IDLE,
        DS_PULSE
    } dom_state_e;
endpackage

// File: rtl/eng_rst_fsm.sv
module eng_rst_fsm
    import eng_rst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_set_i,
    input  logic req_clr_i,
    input  logic cat_ack_i,
    input  logic idle_i,
    input  logic err_i,
    output logic req_o,
    output logic rdy_o,
    output logic cat_o
);
    eng_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ES_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ES_IDLE: begin
                if (err_i)          state_d = ES_CATERR;
                else if (req_set_i) state_d = ES_QUIESCE;
            end
            ES_QUIESCE: begin
                if (err_i)          state_d = ES_CATERR;
                else if (req_clr_i) state_d = ES_IDLE;
                else if (idle_i)    state_d = ES_READY;
            end
            ES_READY: begin
                if (err_i)          state_d = ES_CATERR;
                else if (req_clr_i) state_d = ES_IDLE;
            end
            ES_CATERR: begin
                if (cat_ack_i && !err_i) state_d = ES_IDLE;
            end
            default: state_d = ES_IDLE;
        endcase
    end

    always_comb begin
        req_o = 1'b0;
        rdy_o = 1'b0;
        cat_o = 1'b0;
        unique case (state_q)
            ES_IDLE:    ;
            ES_QUIESCE: req_o = 1'b1;
            ES_READY: begin
                req_o = 1'b1;
                rdy_o = 1'b1;
            end
            ES_CATERR:  cat_o = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/dom_rst_timer.sv
module dom_rst_timer
    import eng_rst_pkg::*;
#(
    parameter int CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o
);
    localparam int CW = $clog2(CYC + 1);

    dom_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_IDLE:  if (start_i)      state_d = DS_PULSE;
            DS_PULSE: if (cnt_q == '0)  state_d = DS_IDLE;
            default:  state_d = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == DS_IDLE && start_i) begin
            cnt_q <= CW'(CYC - 1);
        end else if (state_q == DS_PULSE && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        active_o = (state_q == DS_PULSE);
    end
endmodule

// File: rtl/eng_reset_ctrl.sv
module eng_reset_ctrl
    import eng_rst_pkg::*;
#(
    parameter int NUM_ENG = 2,
    parameter int DOM_W = 8,
    parameter logic [DOM_W-1:0] DOM_VALID = 'hBF,
    parameter int RST_CYCLES = 8,
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_ENG-1:0] eng_idle_i,
    input  logic [NUM_ENG-1:0] eng_err_i,
    output logic [NUM_ENG-1:0] eng_quiesce_o,
    output logic [DOM_W-1:0]   dom_rst_o
);
    logic [NUM_ENG-1:0] eng_req, eng_rdy, eng_cat;
    logic [DOM_W-1:0]   dom_active;
    logic               dom_wr;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign dom_wr = bus_we && (bus_addr == '0);

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        logic hit;
        logic set_req, clr_req, ack_cat;
        assign hit     = bus_we && (bus_addr == ADDR_W'(e + 1));
        assign set_req = hit && bus_wdata[CTL_EN_OFS + CTL_REQ] && bus_wdata[CTL_REQ];
        assign clr_req = hit && bus_wdata[CTL_EN_OFS + CTL_REQ] && !bus_wdata[CTL_REQ];
        assign ack_cat = hit && bus_wdata[CTL_EN_OFS + CTL_CAT] && bus_wdata[CTL_CAT];

        eng_rst_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_set_i (set_req),
            .req_clr_i (clr_req),
            .cat_ack_i (ack_cat),
            .idle_i    (eng_idle_i[e]),
            .err_i     (eng_err_i[e]),
            .req_o     (eng_req[e]),
            .rdy_o     (eng_rdy[e]),
            .cat_o     (eng_cat[e])
        );
        assign eng_quiesce_o[e] = eng_req[e];
    end

    for (genvar d = 0; d < DOM_W; d++) begin : g_dom
        if (DOM_VALID[d]) begin : g_on
            dom_rst_timer #(.CYC(RST_CYCLES)) u_tmr (
                .clk      (clk),
                .rst_n    (rst_n),
                .start_i  (dom_wr && bus_wdata[d]),
                .active_o (dom_active[d])
            );
            assign dom_rst_o[d] = dom_active[d] | dom_active[0];
        end else begin : g_off
            assign dom_active[d] = 1'b0;
            assign dom_rst_o[d]  = 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) begin
            bus_rdata[DOM_W-1:0] = dom_active;
        end
        for (int e = 0; e < NUM_ENG; e++) begin
            if (bus_addr == ADDR_W'(e + 1)) begin
                bus_rdata[CTL_REQ] = eng_req[e];
                bus_rdata[CTL_RDY] = eng_rdy[e];
                bus_rdata[CTL_CAT] = eng_cat[e];
            end
        end
    end
endmodule

// File: rtl/eng_reset_ctrl_chk.sv
module eng_reset_ctrl_chk #(
    parameter int NUM_ENG = 2,
    parameter int DOM_W = 8,
    parameter logic [DOM_W-1:0] DOM_VALID = 'hBF,
    parameter int RST_CYCLES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_ENG-1:0] eng_idle_i,
    input logic [NUM_ENG-1:0] eng_req,
    input logic [NUM_ENG-1:0] eng_rdy,
    input logic [NUM_ENG-1:0] eng_cat,
    input logic [DOM_W-1:0]   dom_active,
    input logic [DOM_W-1:0]   dom_rst_o
);
    localparam int CW = $clog2(RST_CYCLES + 2);

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_e
        // R3: ready only with a pending request
        p_rdy_has_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
            eng_rdy[e] |-> eng_req[e]);
        // R3: ready rises only after idle was seen
        p_rdy_after_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(eng_rdy[e]) |-> $past(eng_idle_i[e]));
        // R6: a fault excludes request and ready
        p_cat_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
            eng_cat[e] |-> (!eng_req[e] && !eng_rdy[e]));
    end

    // R9: full reset drives every valid domain
    p_full_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dom_active[0] |-> (dom_rst_o == DOM_VALID));

    for (genvar d = 0; d < DOM_W; d++) begin : g_d
        if (DOM_VALID[d]) begin : g_on
            logic [CW-1:0] run_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)             run_q <= '0;
                else if (dom_active[d]) run_q <= run_q + 1'b1;
                else                    run_q <= '0;
            end
            // R10: a pulse never runs past its length
            p_no_extend_r10: assert property (@(posedge clk) disable iff (!rst_n)
                dom_active[d] |-> (run_q < CW'(RST_CYCLES)));
            // R8: a pulse ends after exactly RST_CYCLES cycles
            p_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(dom_active[d]) |-> (run_q == CW'(RST_CYCLES)));
        end
    end
endmodule

bind eng_reset_ctrl eng_reset_ctrl_chk #(
    .NUM_ENG    (NUM_ENG),
    .DOM_W      (DOM_W),
    .DOM_VALID  (DOM_VALID),
    .RST_CYCLES (RST_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eng_idle_i (eng_idle_i),
    .eng_req    (eng_req),
    .eng_rdy    (eng_rdy),
    .eng_cat    (eng_cat),
    .dom_active (dom_active),
    .dom_rst_o  (dom_rst_o)
);

// File: tb/eng_reset_ctrl_tb.sv
module eng_reset_ctrl_tb;
    localparam int NUM_ENG = 2;
    localparam int DOM_W = 8;
    localparam int RST_CYCLES = 8;
    localparam int ADDR_W = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_we = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [NUM_ENG-1:0] eng_idle_i = '0;
    logic [NUM_ENG-1:0] eng_err_i = '0;
    logic [NUM_ENG-1:0] eng_quiesce_o;
    logic [DOM_W-1:0]   dom_rst_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    eng_reset_ctrl #(
        .NUM_ENG(NUM_ENG), .DOM_W(DOM_W), .DOM_VALID(8'hBF),
        .RST_CYCLES(RST_CYCLES), .ADDR_W(ADDR_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_idle_i(eng_idle_i),
        .eng_err_i(eng_err_i), .eng_quiesce_o(eng_quiesce_o), .dom_rst_o(dom_rst_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 domain word", 0, 0);
        rd_chk("R1 engine0 word", 1, 0);
        rd_chk("R1 engine1 word", 2, 0);
        chk("R1 outputs", {eng_quiesce_o, dom_rst_o}, 0);
    endtask

    task automatic t_request;
        wr(1, 32'h0000_0001);
        rd_chk("R2 no enable bit", 1, 0);
        wr(1, 32'h0001_0001);
        rd_chk("R3 request set", 1, 32'h1);
        chk("R3 quiesce high", 32'(eng_quiesce_o), 32'h1);
        @(negedge clk); @(negedge clk);
        rd_chk("R3 no ready without idle", 1, 32'h1);
        eng_idle_i[0] = 1'b1;
        @(negedge clk);
        rd_chk("R3 ready after idle", 1, 32'h3);
    endtask

    task automatic t_readonly;
        wr(1, 32'h0002_0000);
        rd_chk("R4 ready read-only", 1, 32'h3);
    endtask

    task automatic t_cancel;
        wr(1, 32'h0001_0000);
        rd_chk("R5 cancel clears", 1, 0);
        chk("R5 quiesce low", 32'(eng_quiesce_o), 0);
        wr(1, 32'h0001_0001);
        rd_chk("R3 request while idle high", 1, 32'h1);
        @(negedge clk);
        rd_chk("R3 ready next cycle", 1, 32'h3);
        wr(1, 32'h0001_0000);
        rd_chk("R5 cancel from ready", 1, 0);
        eng_idle_i[0] = 1'b0;
    endtask

    task automatic t_fault;
        wr(2, 32'h0001_0001);
        rd_chk("R3 engine1 request", 2, 32'h1);
        @(negedge clk);
        eng_err_i[1] = 1'b1;
        @(negedge clk);
        eng_err_i[1] = 1'b0;
        rd_chk("R6 fault latched", 2, 32'h4);
        chk("R6 quiesce dropped", 32'(eng_quiesce_o), 0);
        rd_chk("R6 engine0 unaffected", 1, 0);
        wr(2, 32'h0001_0001);
        rd_chk("R6 request ignored", 2, 32'h4);
        wr(2, 32'h0000_0004);
        rd_chk("R2 ack without enable", 2, 32'h4);
        wr(2, 32'h0004_0004);
        rd_chk("R7 fault acknowledged", 2, 0);
    endtask

    task automatic t_domain;
        wr(0, 32'h0000_0002);
        for (int k = 0; k <= RST_CYCLES; k++) begin
            chk($sformatf("R8 domain1 pulse k=%0d", k), 32'(dom_rst_o[1]), 32'(k < RST_CYCLES));
            rd_chk("R8 domain bit readback", 0, (k < RST_CYCLES) ? 32'h2 : 32'h0);
            chk("R8 other domains quiet", 32'(dom_rst_o & 8'hFD), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_rewrite;
        wr(0, 32'h0000_0008);
        for (int k = 0; k <= RST_CYCLES; k++) begin
            chk($sformatf("R10 domain3 k=%0d", k), 32'(dom_rst_o[3]), 32'(k < RST_CYCLES));
            if (k == 3) begin bus_we = 1'b1; bus_wdata = 32'h8; end
            else begin bus_we = 1'b0; bus_wdata = 0; end
            @(negedge clk);
        end
        bus_we = 1'b0;
        @(negedge clk);
        chk("R10 no late restart", 32'(dom_rst_o), 0);
    endtask

    task automatic t_full;
        wr(0, 32'h0000_0001);
        for (int k = 0; k <= RST_CYCLES; k++) begin
            chk($sformatf("R9 full reset k=%0d", k), 32'(dom_rst_o),
                (k < RST_CYCLES) ? 32'hBF : 32'h0);
            @(negedge clk);
        end
    endtask

    task automatic t_unused;
        wr(0, 32'hFFFF_FF40);
        rd_chk("R11 bit6 reads 0", 0, 0);
        chk("R11 no output", 32'(dom_rst_o), 0);
        wr(0, 32'h0000_00FF);
        rd_chk("R11 only valid bits", 0, 32'hBF);
        repeat (RST_CYCLES + 1) @(negedge clk);
        rd_chk("R8 all cleared", 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_request();
        t_readonly();
        t_cancel();
        t_fault();
        t_domain();
        t_rewrite();
        t_full();
        t_unused();
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule